// File: doc/BRIEF.md
# Rainbow Chain Precomputation Controller

This block builds rainbow-table chains by cycling keys through an external block-cipher pipeline that has a fixed latency. Start points are counted upward from a programmed first value to a programmed last value. Each start point becomes the first key of a chain. Every ciphertext that returns from the pipeline is unscrambled and cut to 56 bits. The pass's column number is folded into that value, and a mask and base confine it to a reduced key space. The result goes straight back into the pipeline as the chain's next key. When a chain has completed its programmed number of passes, the block reports the start point and the final reduced key as a pair.

The pipeline has one slot per stage. Each slot carries its own independent chain, so a deep pipeline stays full of interleaved chains. On every step the returning slot either continues its own chain or, once that chain has finished, takes the next start point. The plaintext is captured and scrambled once while the block is disabled, and that value feeds every encryption of the run.

The pipeline only moves on cycles where the block asserts its step output. Pausing therefore freezes every chain in flight, and nothing is lost or repeated when the run resumes. A done flag marks the moment the last chain has delivered its pair.

Top module: `rainbow_chain_precomp`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released with enable low, encStep, encReqValid, pairValid and done are all 0.
- R2: encReqText equals the plaintext sampled on the last clock edge where enable was low, with output bit i taken from input bit (9*i mod 64). Changes to cfgPlain while enable is high have no effect on any request or pair.
- R3: Fresh keys are issued as the start points cfgFirst, cfgFirst+1, and so on up to cfgLast inclusive. Each start point is issued exactly once per run and reported exactly once in a pair.
- R4: A response consumed on a step belongs to the request issued LAT steps earlier. The reduced key is computed in three stages. First, x is formed with bit j taken from response bit (57*j mod 64). Next, v is the low 56 bits of x XORed with the zero-extended column number of that request, counting from 0. Finally, the key is (v & cfgKeyMask) | (cfgKeyBase & ~cfgKeyMask). When the chain continues, this key is requested on the same step.
- R5: A chain performs exactly cfgChainLen encryptions (cfgChainLen at least 1). One cycle after the step that consumes its last response, pairValid is 1 for one cycle, with pairStart set to the start point and pairEnd set to the last reduced key.
- R6: A slot whose chain finishes takes the next start point on the same step. If no start points remain, the slot is left empty and encReqValid is 0 on that step.
- R7: encStep is 1 exactly when enable is 1 and pause is 0. While paused, no request is issued and no chain advances, and a resumed run produces the same pairs as an unpaused one.
- R8: done becomes 1 in the same cycle as the pair of the final chain, and stays 1 until enable goes low.
- R9: With enable low, all chains in flight are discarded, the start counter reloads from cfgFirst, and pairValid and done are 0. Responses that return later from discarded chains are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low clears the run and loads the configuration |
| pause | input | 1 | Freezes the pipeline and all chains |
| cfgFirst | input | 56 | First start point |
| cfgLast | input | 56 | Last start point (inclusive) |
| cfgChainLen | input | COLW | Encryptions per chain |
| cfgPlain | input | 64 | Chosen plaintext |
| cfgKeyMask | input | 56 | 1 marks a key bit that comes from the reduction |
| cfgKeyBase | input | 56 | Values for key bits fixed by the mask |
| encStep | output | 1 | Pipeline advances on this cycle |
| encReqValid | output | 1 | The request entering the pipeline carries a live chain |
| encReqKey | output | 56 | Key entering the pipeline |
| encReqText | output | 64 | Scrambled plaintext entering the pipeline |
| encRspValid | input | 1 | Valid tag leaving the pipeline |
| encRspData | input | 64 | Ciphertext leaving the pipeline |
| pairValid | output | 1 | Completed chain pair is present |
| pairStart | output | 56 | Start point of the completed chain |
| pairEnd | output | 56 | End point of the completed chain |
| done | output | 1 | Last chain of the range has completed |

## Verification
A slot ring pointer that drifts out of step with the pipeline shows up in the same step as the first misaligned response. It attaches a ciphertext to the wrong start point or column, so encReqKey differs from the model on that step, and every pair downstream of it is also wrong. A wrong column count shows up in pairValid timing one cycle after the chain should have closed. A wrong occupancy count or start counter shows up as done rising early or late, or as a start point that is missing or repeated in the pairs. The bench compares every output on every clock against a behavioural model. It also recomputes each pair's end point from its start point independently.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  localparam int KEY_W = 56;
  localparam int BLK_W = 64;
  // odd strides give a bijective bit scramble; 9*57 = 1 mod 64
  localparam int FWD_STRIDE = 9;
  localparam int INV_STRIDE = 57;

  typedef logic [KEY_W-1:0] key_t;
  typedef logic [BLK_W-1:0] blk_t;

  typedef struct packed {
    logic step;       // pipeline moves this cycle
    logic loadText;   // capture plaintext, clear pair output
    logic takeFresh;  // request key is the next start point
    logic emitPair;   // head slot's chain finishes on this step
    logic reqValid;   // request carries a live chain
  } strobe_t;

  function automatic blk_t scramble(input blk_t x, input int stride);
    blk_t y;
    for (int i = 0; i < BLK_W; i++) y[i] = x[(i * stride) % BLK_W];
    return y;
  endfunction
endpackage

// File: rtl/rcp_control.sv
module rcp_control import rcp_pkg::*; #(
  parameter int LAT  = 48,
  parameter int COLW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            pause,
  input  key_t            cfgFirst,
  input  key_t            cfgLast,
  input  logic [COLW-1:0] cfgChainLen,
  input  logic            encRspValid,
  output strobe_t         strb,
  output key_t            headStart,
  output logic [COLW-1:0] headCol,
  output key_t            freshKey,
  output logic            done
);
  localparam int PTR_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(LAT - 1);

  logic [LAT-1:0]   slotLive;
  key_t             startMem [LAT];
  logic [COLW-1:0]  colMem   [LAT];
  logic [PTR_W-1:0] ptr;
  key_t             nextStart;
  logic             haveMore;
  logic [CNT_W-1:0] liveCount;
  logic             doneQ;

  logic             headLive, finish, carry, fresh, step, moreNext;
  logic [COLW-1:0]  colNext;
  logic [CNT_W-1:0] liveNext;

  always_comb begin
    headLive  = slotLive[ptr];
    headStart = startMem[ptr];
    headCol   = colMem[ptr];
    colNext   = headCol + 1'b1;
    finish    = headLive && (colNext == cfgChainLen);
    carry     = headLive && !finish;
    fresh     = !carry && haveMore;
    step      = enable && !pause;
    liveNext  = liveCount + CNT_W'(fresh) - CNT_W'(finish);
    moreNext  = haveMore && !(fresh && (nextStart == cfgLast));
    strb.step      = step;
    strb.loadText  = !enable;
    strb.takeFresh = fresh;
    strb.emitPair  = step && finish;
    strb.reqValid  = step && (carry || fresh);
  end

  assign freshKey = nextStart;
  assign done     = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      slotLive  <= '0;
      nextStart <= '0;
      haveMore  <= 1'b0;
      liveCount <= '0;
      doneQ     <= 1'b0;
    end else if (!enable) begin
      ptr       <= '0;
      slotLive  <= '0;
      nextStart <= cfgFirst;
      haveMore  <= 1'b1;
      liveCount <= '0;
      doneQ     <= 1'b0;
    end else if (step) begin
      slotLive[ptr] <= carry || fresh;
      ptr           <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
      if (fresh) nextStart <= nextStart + 1'b1;
      haveMore  <= moreNext;
      liveCount <= liveNext;
      if (finish && (liveNext == '0) && !moreNext) doneQ <= 1'b1;
    end
  end

  // per-slot chain record, rewritten as the slot re-enters the pipeline
  always_ff @(posedge clk) begin
    if (step) begin
      startMem[ptr] <= carry ? headStart : nextStart;
      colMem[ptr]   <= carry ? colNext : '0;
    end
  end

  p_rsp_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    (step && headLive) |-> encRspValid);

  p_live_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    liveCount == CNT_W'($countones(slotLive)));

  p_pause_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && pause) |=> ($stable(ptr) && $stable(nextStart) && $stable(slotLive)));

  p_done_drained_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> ((liveCount == '0) && !haveMore));
endmodule

// File: rtl/rcp_datapath.sv
module rcp_datapath import rcp_pkg::*; #(
  parameter int COLW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  blk_t            cfgPlain,
  input  key_t            cfgKeyMask,
  input  key_t            cfgKeyBase,
  input  blk_t            encRspData,
  input  key_t            headStart,
  input  logic [COLW-1:0] headCol,
  input  key_t            freshKey,
  output logic            encStep,
  output logic            encReqValid,
  output key_t            encReqKey,
  output blk_t            encReqText,
  output logic            pairValid,
  output key_t            pairStart,
  output key_t            pairEnd
);
  blk_t textQ;
  key_t mixed, reduced;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) textQ <= '0;
    else if (strb.loadText) textQ <= scramble(cfgPlain, FWD_STRIDE);
  end

  always_comb begin
    mixed   = key_t'(scramble(encRspData, INV_STRIDE)) ^ KEY_W'(headCol);
    reduced = (mixed & cfgKeyMask) | (cfgKeyBase & ~cfgKeyMask);
  end

  assign encReqKey   = strb.takeFresh ? freshKey : reduced;
  assign encReqText  = textQ;
  assign encStep     = strb.step;
  assign encReqValid = strb.reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairValid <= 1'b0;
      pairStart <= '0;
      pairEnd   <= '0;
    end else if (strb.loadText) begin
      pairValid <= 1'b0;
    end else begin
      pairValid <= strb.emitPair;
      if (strb.emitPair) begin
        pairStart <= headStart;
        pairEnd   <= reduced;
      end
    end
  end

  p_end_in_space_r4: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> (((pairEnd ^ cfgKeyBase) & ~cfgKeyMask) == '0));

  p_pair_after_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> $past(strb.step));
endmodule

// File: rtl/rainbow_chain_precomp.sv
module rainbow_chain_precomp import rcp_pkg::*; #(
  parameter int LAT  = 48,
  parameter int COLW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            pause,
  input  logic [55:0]     cfgFirst,
  input  logic [55:0]     cfgLast,
  input  logic [COLW-1:0] cfgChainLen,
  input  logic [63:0]     cfgPlain,
  input  logic [55:0]     cfgKeyMask,
  input  logic [55:0]     cfgKeyBase,
  output logic            encStep,
  output logic            encReqValid,
  output logic [55:0]     encReqKey,
  output logic [63:0]     encReqText,
  input  logic            encRspValid,
  input  logic [63:0]     encRspData,
  output logic            pairValid,
  output logic [55:0]     pairStart,
  output logic [55:0]     pairEnd,
  output logic            done
);
  strobe_t         strb;
  key_t            headStart, freshKey;
  logic [COLW-1:0] headCol;

  rcp_control #(.LAT(LAT), .COLW(COLW)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pause(pause),
    .cfgFirst(cfgFirst), .cfgLast(cfgLast), .cfgChainLen(cfgChainLen),
    .encRspValid(encRspValid), .strb(strb), .headStart(headStart),
    .headCol(headCol), .freshKey(freshKey), .done(done)
  );

  rcp_datapath #(.COLW(COLW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgPlain(cfgPlain),
    .cfgKeyMask(cfgKeyMask), .cfgKeyBase(cfgKeyBase), .encRspData(encRspData),
    .headStart(headStart), .headCol(headCol), .freshKey(freshKey),
    .encStep(encStep), .encReqValid(encReqValid), .encReqKey(encReqKey),
    .encReqText(encReqText), .pairValid(pairValid), .pairStart(pairStart),
    .pairEnd(pairEnd)
  );
endmodule

// File: tb/tb_rainbow_chain_precomp.sv
`timescale 1ns/1ps
module tb_rainbow_chain_precomp;
  localparam int LAT = 6;
  localparam int COLW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, enable, pause;
  logic [55:0] cfgFirst, cfgLast, cfgKeyMask, cfgKeyBase;
  logic [COLW-1:0] cfgChainLen;
  logic [63:0] cfgPlain;
  logic encStep, encReqValid, encRspValid, pairValid, done;
  logic [55:0] encReqKey, pairStart, pairEnd;
  logic [63:0] encReqText, encRspData;

  rainbow_chain_precomp #(.LAT(LAT), .COLW(COLW)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .pause(pause),
    .cfgFirst(cfgFirst), .cfgLast(cfgLast), .cfgChainLen(cfgChainLen),
    .cfgPlain(cfgPlain), .cfgKeyMask(cfgKeyMask), .cfgKeyBase(cfgKeyBase),
    .encStep(encStep), .encReqValid(encReqValid), .encReqKey(encReqKey),
    .encReqText(encReqText), .encRspValid(encRspValid), .encRspData(encRspData),
    .pairValid(pairValid), .pairStart(pairStart), .pairEnd(pairEnd), .done(done)
  );

  // ---------------- stand-in cipher pipeline ----------------
  function automatic logic [63:0] cipher(logic [55:0] k, logic [63:0] t);
    logic [63:0] x;
    x = t ^ {k, k[55:48]};
    x = x * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 31);
    x = x * 64'hBF58476D1CE4E5B9;
    return x ^ (x >> 29);
  endfunction

  logic [LAT-1:0] pv;
  logic [63:0]    pd [LAT];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pv <= '0;
      for (int i = 0; i < LAT; i++) pd[i] <= '0;
    end else if (encStep) begin
      pv[0] <= encReqValid;
      pd[0] <= cipher(encReqKey, encReqText);
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end
  assign encRspValid = pv[LAT-1];
  assign encRspData  = pd[LAT-1];

  // ---------------- behavioural reference ----------------
  typedef struct packed {
    logic        v;
    logic [55:0] s;
    logic [15:0] col;
    logic [55:0] k;
  } ent_t;

  ent_t mq[$];
  logic [55:0] mNext, mPairS, mPairE;
  logic [63:0] mText;
  bit mMore, mDone, mPairV;
  int nTests = 0, nFail = 0, pairsSeen = 0;
  bit finished = 0;
  int seen[longint];

  function automatic logic [63:0] fwdPerm(logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[i] = x[(9 * i) % 64];
    return y;
  endfunction

  function automatic logic [55:0] reduceKey(logic [63:0] c, logic [15:0] col);
    logic [63:0] x;
    logic [55:0] v;
    for (int j = 0; j < 64; j++) x[j] = c[(57 * j) % 64];
    v = x[55:0] ^ {40'd0, col};
    return (v & cfgKeyMask) | (cfgKeyBase & ~cfgKeyMask);
  endfunction

  function automatic logic [55:0] chainEnd(logic [55:0] s);
    logic [55:0] k;
    k = s;
    for (int c = 0; c < int'(cfgChainLen); c++) k = reduceKey(cipher(k, mText), 16'(c));
    return k;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearModel();
    mq.delete();
    for (int i = 0; i < LAT; i++) mq.push_back('0);
    mNext = cfgFirst; mMore = 1; mDone = 0; mPairV = 0;
    mText = fwdPerm(cfgPlain);
  endtask

  // inputs are already driven at this negedge
  task automatic tick();
    ent_t h;
    bit st, finish, carry, fresh, rv, anyLive;
    logic [55:0] red;
    logic [15:0] cn;
    #1;
    st = enable && !pause;
    h = mq[0];
    red = reduceKey(cipher(h.k, mText), h.col);
    cn = h.col + 16'd1;
    finish = h.v && (cn == cfgChainLen);
    carry = h.v && !finish;
    fresh = !carry && mMore;
    rv = st && (carry || fresh);
    chk(encStep == st, "R7", "encStep", 64'(encStep), 64'(st));
    chk(encReqValid == rv, "R6", "encReqValid", 64'(encReqValid), 64'(rv));
    if (rv) begin
      if (carry) chk(encReqKey == red, "R4", "fed-back key", 64'(encReqKey), 64'(red));
      else       chk(encReqKey == mNext, "R3", "fresh start point", 64'(encReqKey), 64'(mNext));
      chk(encReqText == mText, "R2", "encReqText", encReqText, mText);
    end
    chk(pairValid == mPairV, "R5", "pairValid", 64'(pairValid), 64'(mPairV));
    if (mPairV && pairValid) begin
      chk(pairStart == mPairS, "R3", "pairStart", 64'(pairStart), 64'(mPairS));
      chk(pairEnd == mPairE, "R5", "pairEnd", 64'(pairEnd), 64'(mPairE));
      chk(pairEnd == chainEnd(pairStart), "R5", "independent chain end", 64'(pairEnd), 64'(chainEnd(pairStart)));
      chk(!seen.exists(longint'(pairStart)), "R3", "duplicate start point", 64'(pairStart), 64'(0));
      seen[longint'(pairStart)] = 1;
      pairsSeen++;
    end
    chk(done == mDone, "R8", "done", 64'(done), 64'(mDone));
    // model advances as the coming edge will
    if (!rstN || !enable) begin
      clearModel();
    end else if (st) begin
      mPairV = finish;
      if (finish) begin mPairS = h.s; mPairE = red; end
      void'(mq.pop_front());
      if (carry)      mq.push_back({1'b1, h.s, cn, red});
      else if (fresh) mq.push_back({1'b1, mNext, 16'd0, mNext});
      else            mq.push_back('0);
      if (fresh) begin
        if (mNext == cfgLast) mMore = 0;
        mNext = mNext + 56'd1;
      end
      anyLive = 0;
      foreach (mq[i]) if (mq[i].v) anyLive = 1;
      if (finish && !mMore && !anyLive) mDone = 1;
    end else begin
      mPairV = 0;
    end
    @(negedge clk);
  endtask

  task automatic configure(logic [55:0] f, logic [55:0] l, logic [15:0] len);
    enable = 0; pause = 0;
    cfgFirst = f; cfgLast = l; cfgChainLen = len;
    repeat (2) tick();
    seen.delete();
    pairsSeen = 0;
    enable = 1;
  endtask

  task automatic runToDone(int limit, int expPairs, bit pauses, bit swapText);
    int i;
    i = 0;
    while (!mDone && i < limit) begin
      if (pauses) pause = ((i % 9) >= 6);
      if (swapText && i == 15) cfgPlain = ~cfgPlain ^ 64'h0123_4567_89AB_CDEF; // R2: ignored while enabled
      tick();
      i++;
    end
    pause = 0;
    repeat (3) tick();
    chk(done == 1'b1, "R8", "done after run", 64'(done), 64'(1));
    chk(pairsSeen == expPairs, "R3", "pair count", 64'(pairsSeen), 64'(expPairs));
  endtask

  initial begin
    rstN = 0; enable = 0; pause = 0;
    cfgFirst = 56'd100; cfgLast = 56'd119; cfgChainLen = 16'd3;
    cfgPlain = 64'h0102_0304_0506_0708;
    cfgKeyMask = 56'h00_00FF_FFFF_FFFF;
    cfgKeyBase = 56'hA5_5A00_0000_0000;
    @(negedge clk);
    clearModel();
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1: idle outputs after reset
    chk(encReqValid == 0 && pairValid == 0 && done == 0 && encStep == 0, "R1",
        "idle outputs", {60'd0, encStep, encReqValid, pairValid, done}, 64'd0);

    // long run: more chains than slots, pause bursts, plaintext changed mid-run
    configure(56'd100, 56'd119, 16'd3);
    runToDone(2000, 20, 1, 1);

    // abandon a run part way (R9)
    configure(56'd200, 56'd230, 16'd4);
    repeat (20) tick();
    enable = 0;
    tick();
    tick();
    chk(pairValid == 0 && done == 0 && encReqValid == 0, "R9", "cleared on disable",
        {61'd0, pairValid, done, encReqValid}, 64'd0);

    // fewer chains than slots, long chains, stale responses in the pipe (R6, R9)
    configure(56'd0, 56'd3, 16'd10);
    runToDone(2000, 4, 0, 0);

    // single chain of length one
    cfgKeyMask = 56'hFF_FFFF_FFFF_FFFF;
    configure(56'd5, 56'd5, 16'd1);
    runToDone(500, 1, 1, 0);

    // done holds until enable drops (R8)
    repeat (5) tick();
    chk(done == 1'b1, "R8", "done held", 64'(done), 64'(1));
    enable = 0;
    tick();
    tick();
    chk(done == 1'b0, "R9", "done cleared by disable", 64'(done), 64'(0));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule